// File: doc/BRIEF.md
# Set-Associative Cache Lookup and Replacement Controller

This block is the tag side of a small set-associative cache. A requester presents a byte address. The block splits the address into a byte offset, a set index and a tag. It compares the tag against every valid way of the indexed set in the same cycle.

On a hit it returns the matching way and the stored word at once. On a miss it holds off the requester, chooses a victim way, and fills that way with one word from a single-cycle backing-memory read port. The access then completes as a hit.

The victim choice can be changed while the block runs. Three orders are offered: least recently used, first-in-first-out, and a pseudo-random order. Two counters, one for hits and one for misses, let the same reference trace be compared across these orders.

Top module: `sa_cache_ctrl`

## Requirements
- R1: The offset is the low OFF_W (2) address bits, the set index is the next IDX_W (8) bits, and the tag is every bit above them. Addresses that differ only in the offset reach the same word. A line in one set never affects lookups in another set.
- R2: When `req_valid` is high and a valid way in the indexed set holds the address tag, `hit` is 1 and `req_ready` is 1 in that same cycle. `hit_way` gives the matching way, and `rd_data` gives its stored word.
- R3: On a miss, `req_ready` is 0 in the request cycle. In the next cycle `mem_rd` is 1, `mem_addr` carries the block address with its offset bits zero, and `req_ready` stays 0. In the cycle after that, the held request completes with `hit`=1, the filled way on `hit_way`, and the fetched word on `rd_data`.
- R4: Under every policy, a miss fills the lowest-numbered invalid way of the set if one exists.
- R5: With `policy`=0 and the set full, the victim is the least recently used way. Both a hit and a fill count as a use.
- R6: With `policy`=1 and the set full, the victim is the way that follows the most recently filled way of that set, counting modulo WAYS. Hits do not change it.
- R7: With `policy`=2 or 3 and the set full, the victim is the low log2(WAYS) bits of a 16-bit LFSR. The LFSR value used is the one it holds in the miss cycle. The LFSR shifts left every cycle, and bit 0 takes bit15^bit13^bit12^bit10. Reset loads it with 0xACE1.
- R8: `miss_count` rises by 1 for each miss. `hit_count` rises by 1 for each accepted access that is not the completion of a miss.
- R9: A synchronous reset invalidates every line, clears both counters, and resets the replacement state.
- R10: Built with 2 sets and 2 ways under `policy`=0, the block-address trace 0, 8, 0, 6, 8 gives miss, miss, hit, miss, miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy | input | 2 | Victim order: 0 LRU, 1 FIFO, 2/3 pseudo-random |
| req_valid | input | 1 | Request present; held until accepted |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | Request accepted this cycle |
| hit | output | 1 | Tag matched a valid way of the set |
| hit_way | output | log2(WAYS) | Matching way |
| rd_data | output | DATA_W | Word stored in the matching way |
| mem_rd | output | 1 | Fill read strobe |
| mem_addr | output | ADDR_W | Block address of the fill |
| mem_rdata | input | DATA_W | Word returned by memory in the same cycle |
| hit_count | output | CNT_W | Hits counted |
| miss_count | output | CNT_W | Misses counted |

## Verification
A hit is a same-cycle result: `req_ready`, `hit`, `hit_way` and `rd_data` settle combinationally on the address. A miss shows `req_ready` low in its request cycle, a fill strobe one cycle later, and completion two cycles after the request.

The bench drives inputs on the falling edge and samples one nanosecond after it, before the next rising edge. Each expected access is queued before it is driven. The monitor records stall cycles and the fill address while `req_ready` is low, and compares the queued result when the access is accepted.

For the random order, the expected victim is taken from a model LFSR sampled in the first stall cycle. That is the same cycle in which the design latches its victim.

// File: rtl/sa_cache_ctrl.sv
module sa_cache_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SETS   = 256,
  parameter int WAYS   = 4,
  parameter int OFF_W  = 2,
  parameter int CNT_W  = 32,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                policy,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  output logic                      req_ready,
  output logic                      hit,
  output logic [$clog2(WAYS)-1:0]   hit_way,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      mem_rd,
  output logic [ADDR_W-1:0]         mem_addr,
  input  logic [DATA_W-1:0]         mem_rdata,
  output logic [CNT_W-1:0]          hit_count,
  output logic [CNT_W-1:0]          miss_count
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WW    = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [1:0] POL_LRU  = 2'd0;
  localparam logic [1:0] POL_FIFO = 2'd1;

  logic              vld  [SETS][WAYS];
  logic [TAG_W-1:0]  tagm [SETS][WAYS];
  logic [DATA_W-1:0] datm [SETS][WAYS];
  logic [WW-1:0]     age  [SETS][WAYS];
  logic [WW-1:0]     fptr [SETS];

  logic [15:0]      lfsr;
  logic             filling, post_fill;
  logic [IDX_W-1:0] fill_idx;
  logic [TAG_W-1:0] fill_tag;
  logic [WW-1:0]    fill_way;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             inv_any;
  logic [WW-1:0]    inv_way, lru_way, victim;
  logic             miss_det, accept, touch_en;
  logic [IDX_W-1:0] touch_idx;
  logic [WW-1:0]    touch_way;

  assign idx = req_addr[OFF_W +: IDX_W];
  assign tag = req_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    rd_data = '0;
    inv_any = 1'b0;
    inv_way = '0;
    lru_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[idx][w] && tagm[idx][w] == tag) begin
        hit     = 1'b1;
        hit_way = WW'(w);
        rd_data = datm[idx][w];
      end
      if (!vld[idx][w]) begin
        inv_any = 1'b1;
        inv_way = WW'(w);
      end
      if (age[idx][w] == WW'(WAYS - 1)) lru_way = WW'(w);
    end
  end

  always_comb begin
    if (inv_any)                victim = inv_way;
    else if (policy == POL_LRU) victim = lru_way;
    else if (policy == POL_FIFO) victim = fptr[idx];
    else                        victim = lfsr[WW-1:0];
  end

  assign req_ready = !filling && (!req_valid || hit);
  assign miss_det  = req_valid && !filling && !hit;
  assign accept    = req_valid && req_ready;
  assign mem_rd    = filling;
  assign mem_addr  = {fill_tag, fill_idx, {OFF_W{1'b0}}};
  assign touch_en  = filling || accept;
  assign touch_idx = filling ? fill_idx : idx;
  assign touch_way = filling ? fill_way : hit_way;

  always_ff @(posedge clk) begin
    if (rst) begin
      filling    <= 1'b0;
      post_fill  <= 1'b0;
      fill_idx   <= '0;
      fill_tag   <= '0;
      fill_way   <= '0;
      hit_count  <= '0;
      miss_count <= '0;
      lfsr       <= LFSR_SEED;
      for (int s = 0; s < SETS; s++) begin
        fptr[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          vld[s][w] <= 1'b0;
          age[s][w] <= WW'(w);
        end
      end
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (miss_det) begin
        filling    <= 1'b1;
        fill_idx   <= idx;
        fill_tag   <= tag;
        fill_way   <= victim;
        miss_count <= miss_count + CNT_W'(1);
      end
      if (filling) begin
        filling                 <= 1'b0;
        post_fill               <= 1'b1;
        vld[fill_idx][fill_way] <= 1'b1;
        fptr[fill_idx]          <= fill_way + WW'(1);
      end
      if (accept) begin
        post_fill <= 1'b0;
        if (!post_fill) hit_count <= hit_count + CNT_W'(1);
      end
      if (touch_en) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WW'(w) == touch_way)
            age[touch_idx][w] <= '0;
          else if (age[touch_idx][w] < age[touch_idx][touch_way])
            age[touch_idx][w] <= age[touch_idx][w] + WW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (filling) begin
      tagm[fill_idx][fill_way] <= fill_tag;
      datm[fill_idx][fill_way] <= mem_rdata;
    end
  end
endmodule

// File: rtl/sa_cache_ctrl_chk.sv
module sa_cache_ctrl_chk #(
  parameter int CNT_W = 32
)(
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             hit,
  input logic             mem_rd,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  assert_fill_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_miss_starts_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !mem_rd) |=> mem_rd);

  assert_fill_stalls_R3: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !req_ready);

  assert_fill_completes_hit_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && req_valid) |=> (hit && req_ready));

  assert_miss_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !mem_rd) |=> miss_count == $past(miss_count) + CNT_W'(1));

  assert_hit_count_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> $stable(hit_count));
endmodule

bind sa_cache_ctrl sa_cache_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .hit(hit),
  .mem_rd(mem_rd), .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/sa_cache_ctrl_tb.sv
module sa_cache_ctrl_tb;
  typedef struct {
    logic [31:0] addr;
    logic        miss;
    logic        rnd;
    logic [1:0]  way;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] policy = 2'd0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_ready, hit, mem_rd;
  logic [1:0] hit_way;
  logic [31:0] rd_data, mem_addr, mem_rdata, hit_count, miss_count;

  logic req2_valid = 1'b0;
  logic [31:0] req2_addr = '0;
  logic req2_ready, hit2, mem2_rd;
  logic [0:0] hit2_way;
  logic [31:0] rd2_data, mem2_addr, mem2_rdata, hit2_count, miss2_count;

  int n_chk = 0, n_err = 0;
  exp_t q[$];
  logic stalled = 1'b0;
  logic [1:0] rnd_way = '0;
  logic [15:0] lfsr_m;

  always #2 clk = ~clk;

  function automatic logic [31:0] fdata(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:2], 2'b00};
    return {b[15:0], ~b[31:16]};
  endfunction

  assign mem_rdata  = fdata(mem_addr);
  assign mem2_rdata = fdata(mem2_addr);

  sa_cache_ctrl u_dut (
    .clk(clk), .rst(rst), .policy(policy), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .hit(hit), .hit_way(hit_way), .rd_data(rd_data),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .hit_count(hit_count), .miss_count(miss_count));

  sa_cache_ctrl #(.SETS(2), .WAYS(2)) u_dut2 (
    .clk(clk), .rst(rst), .policy(policy), .req_valid(req2_valid), .req_addr(req2_addr),
    .req_ready(req2_ready), .hit(hit2), .hit_way(hit2_way), .rd_data(rd2_data),
    .mem_rd(mem2_rd), .mem_addr(mem2_addr), .mem_rdata(mem2_rdata),
    .hit_count(hit2_count), .miss_count(miss2_count));

  always @(posedge clk)
    if (rst) lfsr_m <= 16'hACE1;
    else     lfsr_m <= {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int t, input int s, input int off);
    return {t[21:0], s[7:0], off[1:0]};
  endfunction

  task automatic access(input logic [31:0] a, input logic miss, input logic [1:0] way,
                        input logic rnd, input string tag);
    exp_t e;
    logic acc;
    e.addr = a; e.miss = miss; e.way = way; e.rnd = rnd; e.tag = tag;
    q.push_back(e);
    req_valid = 1'b1;
    req_addr  = a;
    do begin
      #1 acc = req_ready;
      @(negedge clk);
    end while (!acc);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    if (!rst && req_valid && q.size() > 0) begin
      if (!req_ready) begin
        if (!stalled) rnd_way = lfsr_m[1:0];
        if (mem_rd)
          chk(mem_addr == {q[0].addr[31:2], 2'b00}, "R3 fill address", mem_addr, {q[0].addr[31:2], 2'b00});
        stalled = 1'b1;
      end else begin
        exp_t e;
        logic [1:0] ew;
        e  = q.pop_front();
        ew = e.rnd ? rnd_way : e.way;
        chk(stalled == e.miss, {e.tag, " miss/hit"}, 32'(stalled), 32'(e.miss));
        chk(hit == 1'b1, {e.tag, " hit flag (R2)"}, 32'(hit), 32'd1);
        chk(hit_way == ew, {e.tag, " way"}, 32'(hit_way), 32'(ew));
        chk(rd_data == fdata(e.addr), {e.tag, " data (R3)"}, rd_data, fdata(e.addr));
        stalled = 1'b0;
      end
    end
  end

  task automatic access2(input logic [31:0] blk, input logic miss);
    logic first, acc;
    req2_valid = 1'b1;
    req2_addr  = blk << 2;
    #1 first = req2_ready;
    acc = first;
    @(negedge clk);
    while (!acc) begin
      #1 acc = req2_ready;
      @(negedge clk);
    end
    req2_valid = 1'b0;
    chk(first == !miss, "R10 trace hit/miss", 32'(!first), 32'(miss));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    #1;
    chk(hit_count == 0 && miss_count == 0, "R9 counters at reset", hit_count, 0);
    chk(req_ready == 1'b1 && mem_rd == 1'b0, "R9 idle at reset", {req_ready, mem_rd}, 32'd2);
    @(negedge clk);

    policy = 2'd0;
    access(mk(1, 5, 0), 1, 0, 0, "R4 fill way0");
    access(mk(2, 5, 0), 1, 1, 0, "R4 fill way1");
    access(mk(3, 5, 0), 1, 2, 0, "R4 fill way2");
    access(mk(4, 5, 0), 1, 3, 0, "R4 fill way3");
    access(mk(1, 5, 2), 0, 0, 0, "R1 offset ignored");
    access(mk(1, 6, 0), 1, 0, 0, "R1 other set");
    access(mk(1, 5, 0), 0, 0, 0, "R2 hit");
    access(mk(5, 5, 0), 1, 1, 0, "R5 lru victim");
    access(mk(2, 5, 0), 1, 2, 0, "R5 lru victim");
    access(mk(4, 5, 0), 0, 3, 0, "R5 lru hit");
    access(mk(3, 5, 0), 1, 0, 0, "R5 lru victim");

    policy = 2'd1;
    for (int t = 1; t <= 4; t++) access(mk(t, 9, 0), 1, 2'(t - 1), 0, "R6 fifo fill");
    access(mk(1, 9, 0), 0, 0, 0, "R6 fifo hit");
    access(mk(1, 9, 0), 0, 0, 0, "R6 fifo hit");
    access(mk(5, 9, 0), 1, 0, 0, "R6 fifo victim");
    access(mk(1, 9, 0), 1, 1, 0, "R6 fifo victim");
    access(mk(2, 9, 0), 1, 2, 0, "R6 fifo victim");
    #1;
    chk(miss_count == 15, "R8 miss count", miss_count, 15);
    chk(hit_count == 5, "R8 hit count", hit_count, 5);
    @(negedge clk);

    policy = 2'd2;
    for (int t = 1; t <= 4; t++) access(mk(t, 12, 0), 1, 2'(t - 1), 0, "R4 random fill");
    for (int t = 5; t <= 7; t++) access(mk(t, 12, 0), 1, 0, 1, "R7 random victim");

    do_reset();
    #1;
    chk(hit_count == 0 && miss_count == 0, "R9 counters cleared", hit_count | miss_count, 0);
    @(negedge clk);
    policy = 2'd0;
    access(mk(4, 5, 0), 1, 0, 0, "R9 line invalidated");

    access2(0, 1);
    access2(8, 1);
    access2(0, 0);
    access2(6, 1);
    access2(8, 1);
    #1;
    chk(miss2_count == 4, "R10 miss total", miss2_count, 4);
    chk(hit2_count == 1, "R10 hit total", hit2_count, 1);
    finish_run();
  end
endmodule